// File: doc/BRIEF.md
# Slave-Port Bus Arbiter with Idle Parking

This block decides, cycle by cycle, which of several bus masters is connected to one shared slave. Each master presents a request and a flag saying that it is in the middle of a burst. The arbiter answers with a registered one-hot grant, a valid flag and the index of the connected master. A master that holds the grant while it requests performs its access in that cycle. A master that requests without holding the grant receives it at the next clock edge, so it pays one cycle of latency.

A small configuration register, loaded by a write strobe, selects the arbitration scheme and the idle behaviour. The scheme is either a rotating search or fixed priority. When nobody requests, the idle behaviour leaves the slave unconnected, keeps the last user connected, or connects a chosen master, so that the parked master starts its next access without the extra cycle. A slot counter limits how long one burst can keep the slave while another master is waiting.

Top module: `arb_slave_port`

## Requirements
- R1: With arbitration bit 0 (rotating), the winner is the first requesting master found when searching upward, wrapping around, from the index after the last master won by arbitration. After reset the search starts at master 0.
- R2: With arbitration bit 1 (fixed priority), the requesting master with the lowest index wins.
- R3: With park mode 0 (none) or the reserved mode 3, a cycle with no request leaves grant all-zero after the next edge. A master that is not granted and raises its request is granted at the next edge (one-cycle penalty).
- R4: With park mode 1 (last), a cycle with no request keeps the current grant, so the last user re-accesses with no waiting cycle.
- R5: With park mode 2 (fixed), a cycle with no request connects the master whose number is in the park-id field. That master is then granted before it requests. The park-id field has no effect in modes 0, 1 and 3.
- R6: In park mode 2, a park id that names no connected master (an index of N_MST or above, or one cleared in CONNECTED) gives exactly the mode 0 behaviour.
- R7: The granted master keeps its grant in every cycle in which it requests with its burst flag set, unless the slot limit has expired while another master requests.
- R8: The slot counter reloads to 1 whenever a grant comes from arbitration or parking and counts each held cycle. With slot limit L > 0 and another master requesting, a burst holds the grant for exactly L cycles. The grant then passes to another requester, and the breaking master is excluded from that round.
- R9: A slot limit of 0 means unlimited: a burst is never broken.
- R10: The configuration register loads all fields on a cycle with cfg_wr high, effective from the next cycle. It resets to slot limit 16, rotating arbitration, park mode 0 and park id 0.
- R11: grant is one-hot or zero. conn_vld is high exactly when a master is granted, and conn_idx holds that master's index. Reset clears the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for the configuration fields |
| cfg_arb_fixed | input | 1 | 0 rotating, 1 fixed priority |
| cfg_park_mode | input | 2 | 0 none, 1 last, 2 fixed, 3 reserved (as 0) |
| cfg_park_id | input | ID_W (4) | Master to park on in mode 2 |
| cfg_slot | input | SLOT_W (8) | Burst slot limit in cycles, 0 = unlimited |
| req | input | N_MST (4) | Per-master request |
| burst | input | N_MST (4) | Per-master burst-in-progress flag |
| grant | output | N_MST (4) | One-hot connected master |
| conn_vld | output | 1 | A master is connected |
| conn_idx | output | IDX_W (2) | Index of the connected master |

## Verification
The bound checker examines every cycle for a one-hot grant and for continuity of a held burst. It also checks that a break always moves the grant to a different master, that a zero slot limit never breaks, that idle cycles disconnect or keep the grant according to the park mode, and that fixed priority picks the lowest requester. Other behaviour appears only across a whole scenario, so only the bench's sequences can show it. This covers the rotating pointer walking through successive winners, the exact count of cycles a burst holds before it is broken, the parked master being granted before it asks, the fall-back of an invalid park id, and the reset values of the configuration seen through the arbitration they produce.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_mode_e;

  localparam int unsigned CFG_SLOT_RST = 16;
  localparam logic        CFG_ARB_RST  = 1'b0;

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg #(
  parameter int ID_W   = 4,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              arb_fixed_i,
  input  logic [1:0]        mode_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              arb_fixed_q,
  output logic [1:0]        mode_q,
  output logic [ID_W-1:0]   id_q,
  output logic [SLOT_W-1:0] slot_q
);
  import arb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_fixed_q <= CFG_ARB_RST;
      mode_q      <= PARK_NONE;
      id_q        <= '0;
      slot_q      <= SLOT_W'(CFG_SLOT_RST);
    end else if (wr) begin
      arb_fixed_q <= arb_fixed_i;
      mode_q      <= mode_i;
      id_q        <= id_i;
      slot_q      <= slot_i;
    end
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_MST = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_MST-1:0] cand,
  input  logic [IDX_W-1:0] last,
  input  logic             fixed_mode,
  output logic             hit,
  output logic [IDX_W-1:0] win
);

  // lowest set index of v
  function automatic logic [IDX_W-1:0] lowest_idx(logic [N_MST-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // first set index found searching upward from last+1, with wrap
  function automatic logic [IDX_W-1:0] rotate_idx(logic [N_MST-1:0] v,
                                                  logic [IDX_W-1:0] lst);
    logic [IDX_W-1:0] r;
    int j;
    r = '0;
    for (int k = N_MST; k >= 1; k--) begin
      j = (int'(lst) + k) % N_MST;
      if (v[j]) r = IDX_W'(j);
    end
    return r;
  endfunction

  assign hit = |cand;
  assign win = fixed_mode ? lowest_idx(cand) : rotate_idx(cand, last);

endmodule

// File: rtl/arb_slot_ctr.sv
module arb_slot_ctr #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              advance,
  input  logic [SLOT_W-1:0] limit,
  output logic              expired
);

  logic [SLOT_W-1:0] cnt_q;

  function automatic logic slot_done(logic [SLOT_W-1:0] c, logic [SLOT_W-1:0] l);
    return (l != '0) && (c >= l);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (reload)                    cnt_q <= SLOT_W'(1);
    else if (advance && cnt_q != '1)    cnt_q <= cnt_q + SLOT_W'(1);
  end

  assign expired = slot_done(cnt_q, limit);

endmodule

// File: rtl/arb_slave_port.sv
module arb_slave_port #(
  parameter int               N_MST     = 4,
  parameter int               ID_W      = 4,
  parameter int               SLOT_W    = 8,
  parameter logic [N_MST-1:0] CONNECTED = '1,
  localparam int              IDX_W     = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_arb_fixed,
  input  logic [1:0]        cfg_park_mode,
  input  logic [ID_W-1:0]   cfg_park_id,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [N_MST-1:0]  req,
  input  logic [N_MST-1:0]  burst,
  output logic [N_MST-1:0]  grant,
  output logic              conn_vld,
  output logic [IDX_W-1:0]  conn_idx
);
  import arb_pkg::*;

  logic              cfg_fixed_q;
  logic [1:0]        cfg_mode_q;
  logic [ID_W-1:0]   cfg_id_q;
  logic [SLOT_W-1:0] cfg_slot_q;

  logic [IDX_W-1:0]  own_q, own_d, last_q, last_d;
  logic              vld_q, vld_d;
  logic [N_MST-1:0]  own_mask, cand;
  logic              own_req, own_burst, others_req, cont;
  logic              slot_expired, hold_ev, brk_ev, park_ok;
  logic              pick_hit, ctr_reload, ctr_adv;
  logic [IDX_W-1:0]  pick_win;
  park_mode_e        mode;

  function automatic logic park_target_ok(logic [ID_W-1:0] id);
    if (int'(id) >= N_MST) return 1'b0;
    return CONNECTED[id[IDX_W-1:0]];
  endfunction

  arb_cfg_reg #(.ID_W(ID_W), .SLOT_W(SLOT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .arb_fixed_i(cfg_arb_fixed), .mode_i(cfg_park_mode),
    .id_i(cfg_park_id), .slot_i(cfg_slot),
    .arb_fixed_q(cfg_fixed_q), .mode_q(cfg_mode_q),
    .id_q(cfg_id_q), .slot_q(cfg_slot_q)
  );

  for (genvar g = 0; g < N_MST; g++) begin : g_dec
    assign own_mask[g] = vld_q && (own_q == IDX_W'(g));
  end

  assign mode       = park_mode_e'(cfg_mode_q);
  assign own_req    = |(req & own_mask);
  assign own_burst  = |(burst & own_mask);
  assign others_req = |(req & ~own_mask);
  assign cont       = own_req && own_burst;
  assign hold_ev    = cont && !(slot_expired && others_req);
  assign brk_ev     = cont && slot_expired && others_req;
  assign cand       = brk_ev ? (req & ~own_mask) : req;
  assign park_ok    = park_target_ok(cfg_id_q);

  arb_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .last(last_q), .fixed_mode(cfg_fixed_q),
    .hit(pick_hit), .win(pick_win)
  );

  arb_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .reload(ctr_reload), .advance(ctr_adv),
    .limit(cfg_slot_q), .expired(slot_expired)
  );

  always_comb begin
    own_d      = own_q;
    vld_d      = vld_q;
    last_d     = last_q;
    ctr_reload = 1'b0;
    ctr_adv    = 1'b0;
    if (hold_ev) begin
      ctr_adv = 1'b1;
    end else if (pick_hit) begin
      own_d      = pick_win;
      vld_d      = 1'b1;
      last_d     = pick_win;
      ctr_reload = 1'b1;
    end else begin
      ctr_reload = 1'b1;
      case (mode)
        PARK_LAST:  vld_d = vld_q;
        PARK_FIXED: begin
          if (park_ok) begin
            own_d = cfg_id_q[IDX_W-1:0];
            vld_d = 1'b1;
          end else begin
            vld_d = 1'b0;
          end
        end
        default:    vld_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= IDX_W'(N_MST - 1);
    end else begin
      own_q  <= own_d;
      vld_q  <= vld_d;
      last_q <= last_d;
    end
  end

  assign grant    = own_mask;
  assign conn_vld = vld_q;
  assign conn_idx = own_q;

endmodule

// File: rtl/arb_slave_port_chk.sv
module arb_slave_port_chk #(
  parameter int N_MST  = 4,
  parameter int SLOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MST-1:0]  req,
  input logic [N_MST-1:0]  grant,
  input logic              arb_fixed,
  input logic [1:0]        park_mode,
  input logic [SLOT_W-1:0] slot_lim,
  input logic              hold_ev,
  input logic              brk_ev
);

  a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ev |=> grant == $past(grant));

  a_r8_break_moves: assert property (@(posedge clk) disable iff (!rst_n)
    brk_ev |=> (grant != '0) && ((grant & $past(grant)) == '0));

  a_r9_no_break_unlimited: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_lim == '0) |-> !brk_ev);

  a_r3_idle_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    ((park_mode == 2'd0 || park_mode == 2'd3) && req == '0) |=> grant == '0);

  a_r4_last_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (park_mode == 2'd1 && req == '0) |=> grant == $past(grant));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_fixed && req != '0 && !hold_ev && !brk_ev)
      |=> grant == ($past(req) & (~$past(req) + 1'b1)));

endmodule

bind arb_slave_port arb_slave_port_chk #(.N_MST(N_MST), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
  .arb_fixed(cfg_fixed_q), .park_mode(cfg_mode_q), .slot_lim(cfg_slot_q),
  .hold_ev(hold_ev), .brk_ev(brk_ev)
);

// File: tb/arb_slave_port_tb.sv
`timescale 1ns/1ps
module arb_slave_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_arb_fixed = 1'b0;
  logic [1:0] cfg_park_mode = 2'd0;
  logic [3:0] cfg_park_id = 4'd0;
  logic [7:0] cfg_slot = 8'd0;
  logic [3:0] req = 4'd0, burst = 4'd0;
  logic [3:0] grant;
  logic       conn_vld;
  logic [1:0] conn_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arb_slave_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_arb_fixed(cfg_arb_fixed),
    .cfg_park_mode(cfg_park_mode), .cfg_park_id(cfg_park_id), .cfg_slot(cfg_slot),
    .req(req), .burst(burst), .grant(grant), .conn_vld(conn_vld), .conn_idx(conn_idx)
  );

  // {req, burst, expected grant}: rotating, park none, default slot
  localparam logic [11:0] VEC [0:13] = '{
    12'h000, 12'h101, 12'h101, 12'h000, 12'hF02, 12'hF04, 12'hF08,
    12'hF01, 12'h504, 12'h501, 12'h888, 12'h988, 12'h901, 12'h000
  };

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(logic [3:0] r, logic [3:0] b);
    req = r; burst = b;
    @(posedge clk); #1;
  endtask

  task automatic setcfg(logic f, logic [1:0] m, logic [3:0] id, logic [7:0] s);
    cfg_arb_fixed = f; cfg_park_mode = m; cfg_park_id = id; cfg_slot = s;
    cfg_wr = 1'b1; req = '0; burst = '0;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  // cycles for which grant stays at g while r/b are applied
  task automatic count_hold(logic [3:0] r, logic [3:0] b, logic [3:0] g,
                            int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      cyc(r, b);
      if (grant == g) n++;
      else break;
    end
  endtask

  initial begin
    int n;
    #9 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 reset grant", grant, 0);
    chk("R11 reset conn_vld", conn_vld, 0);

    foreach (VEC[i]) begin
      cyc(VEC[i][11:8], VEC[i][7:4]);
      chk($sformatf("R1 R3 R7 vector %0d", i), grant, VEC[i][3:0]);
    end

    // R10: reset slot 16 and rotating order, seen through a broken burst
    count_hold(4'b0011, 4'b0010, 4'b0010, 40, n);
    chk("R10 R8 default slot hold count", n, 16);
    chk("R8 grant after break", grant, 4'b0001);
    cyc(4'b0000, 4'b0000);
    chk("R3 disconnect", grant, 0);

    setcfg(1'b1, 2'd0, 4'd0, 8'd16);
    cyc(4'b1111, 4'b0000); chk("R2 lowest of 1111", grant, 4'b0001);
    cyc(4'b1111, 4'b0000); chk("R2 lowest again", grant, 4'b0001);
    cyc(4'b1110, 4'b0000); chk("R2 lowest of 1110", grant, 4'b0010);
    cyc(4'b1100, 4'b0000); chk("R2 lowest of 1100", grant, 4'b0100);
    cyc(4'b0000, 4'b0000);

    setcfg(1'b1, 2'd0, 4'd0, 8'd4);
    count_hold(4'b0011, 4'b0001, 4'b0001, 40, n);
    chk("R8 slot 4 hold count", n, 4);
    chk("R8 break goes to other", grant, 4'b0010);
    cyc(4'b0000, 4'b0000);

    setcfg(1'b1, 2'd0, 4'd0, 8'd0);
    count_hold(4'b0011, 4'b0001, 4'b0001, 40, n);
    chk("R9 unlimited burst", n, 40);
    cyc(4'b0000, 4'b0000);
    chk("R3 idle after burst", grant, 0);

    setcfg(1'b0, 2'd1, 4'd1, 8'd16);
    cyc(4'b0100, 4'b0000); chk("R3 first grant", grant, 4'b0100);
    cyc(4'b0000, 4'b0000); chk("R4 parked on last", grant, 4'b0100);
    chk("R11 conn_idx parked", conn_idx, 2);
    chk("R11 conn_vld parked", conn_vld, 1);
    cyc(4'b0000, 4'b0000); chk("R4 R5 id unused in mode 1", grant, 4'b0100);

    setcfg(1'b0, 2'd2, 4'd1, 8'd16);
    cyc(4'b0000, 4'b0000); chk("R5 parked on fixed", grant, 4'b0010);
    chk("R5 conn_idx fixed", conn_idx, 1);
    cyc(4'b0100, 4'b0000); chk("R3 other master", grant, 4'b0100);
    cyc(4'b0000, 4'b0000); chk("R5 back to fixed", grant, 4'b0010);

    setcfg(1'b0, 2'd2, 4'd5, 8'd16);
    cyc(4'b0000, 4'b0000); chk("R6 invalid id disconnects", grant, 0);
    chk("R6 conn_vld", conn_vld, 0);

    setcfg(1'b0, 2'd3, 4'd1, 8'd16);
    cyc(4'b0100, 4'b0000); chk("R3 mode 3 grant", grant, 4'b0100);
    cyc(4'b0000, 4'b0000); chk("R3 mode 3 disconnects", grant, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule